// File: doc/BRIEF.md
# Prioritized Serial-Port Interrupt Index Controller

This block gathers the pending event flags of a serial port into one register and reports the most urgent enabled event as a small numeric index. There are nineteen sources. Each one raises its flag with a one-cycle set pulse. The flag stays latched until software clears it, and a per-source enable mask decides whether the flag counts toward the index and the CPU interrupt line.

Software services the port in a simple loop: read the index, handle the event it names, and repeat until the index reads zero. Each index read clears the flag it reports, so the loop walks the pending events from most urgent to least urgent. A separate write-one-to-clear port lets software drop any set of flags directly. The code map is fixed and sparse: the first eighteen sources take consecutive codes, and the last source skips two codes.

Top module: `uart_irq_index_ctrl`

## Requirements
- R1: While and after synchronous reset, all pending flags are clear, `irq_idx_o` is 0 and `irq_o` is 0.
- R2: A set pulse on `evt_set_i[b]` latches pending flag b at that clock edge. Among enabled pending flags, the lowest bit position wins, so bit 0 is the most urgent.
- R3: The winning bit b is reported as code b+1 for b in 0..17, and bit 18 is reported as code 0x15. Codes 0x13 and 0x14 never appear, and no code exceeds 0x15.
- R4: `irq_idx_o` is 0 whenever no pending flag is enabled by `mask_i`.
- R5: `irq_o` is 1 exactly when the AND of the pending flags and `mask_i` is nonzero.
- R6: When `idx_rd_i` is high with a nonzero index, the flag behind that index is cleared at the clock edge. All other flags are unchanged.
- R7: When `clr_wr_i` is high, each 1 bit in `clr_data_i` clears the matching flag at the clock edge. Each 0 bit leaves its flag unchanged.
- R8: A set pulse and a clear for the same flag in the same cycle leave that flag set. This holds for both the write-one-to-clear port and the index read.
- R9: Flags latch even while masked. Enabling a source later makes its earlier event visible in the index and the interrupt line.
- R10: An index read while the index is 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set_i | input | 19 | One-cycle set pulses, one bit per source, bit 0 the most urgent |
| mask_i | input | 19 | Per-source enable mask |
| clr_wr_i | input | 1 | Write strobe of the write-one-to-clear register |
| clr_data_i | input | 19 | Write data of the write-one-to-clear register |
| idx_rd_i | input | 1 | Index read strobe; clears the reported flag |
| irq_idx_o | output | 5 | Code of the most urgent enabled pending event, 0 if none |
| irq_o | output | 1 | CPU interrupt line |

## Verification
Two pairs of events can fall in the same cycle. A new set pulse can arrive together with the clear it would otherwise lose to, either a write-one-to-clear of the same bit or an index read of that very flag. The bench provokes both by driving the set pulse and the clear on the same clock edge. It then judges the next cycle's index: the flag must still be reported, and a read-clear aimed at the current winner must not touch any other flag, which shows in the code that follows.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned NUM_SRC   = 19;
    localparam int unsigned IDX_W     = 5;
    localparam int unsigned LAST_CODE = 21;

    typedef logic [NUM_SRC-1:0] evt_vec_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef struct packed {
        evt_vec_t win;
        idx_t     code;
        logic     any;
    } sel_t;

    function automatic idx_t src_code(input int unsigned pos);
        if (pos == NUM_SRC - 1)
            return idx_t'(LAST_CODE);
        return idx_t'(pos + 1);
    endfunction

endpackage

// File: rtl/uart_irq_pending.sv
module uart_irq_pending
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t set_i,
    input  evt_vec_t clr_i,
    output evt_vec_t pend_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend_o[g] <= 1'b0;
            else
                pend_o[g] <= set_i[g] | (pend_o[g] & ~clr_i[g]);
        end
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0 && clr_i == '0) |=> $stable(pend_o));

endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t pend_i,
    input  evt_vec_t mask_i,
    output sel_t     sel_o
);

    evt_vec_t active;

    always_comb begin
        active     = pend_i & mask_i;
        sel_o.win  = '0;
        sel_o.code = '0;
        sel_o.any  = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active[i]) begin
                sel_o.win    = '0;
                sel_o.win[i] = 1'b1;
                sel_o.code   = src_code(i);
                sel_o.any    = 1'b1;
            end
        end
    end

    p_code_legal_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_o.code <= idx_t'(LAST_CODE)) && (sel_o.code != 5'h13) && (sel_o.code != 5'h14));

    p_single_winner_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o.win) && (sel_o.any == (sel_o.code != '0)));

endmodule

// File: rtl/uart_irq_index_ctrl.sv
module uart_irq_index_ctrl
    import uart_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   evt_set_i,
    input  logic [NUM_SRC-1:0]   mask_i,
    input  logic                 clr_wr_i,
    input  logic [NUM_SRC-1:0]   clr_data_i,
    input  logic                 idx_rd_i,
    output logic [IDX_W-1:0]     irq_idx_o,
    output logic                 irq_o
);

    evt_vec_t pend;
    evt_vec_t clr_all;
    sel_t     sel;

    always_comb begin
        clr_all = clr_wr_i ? clr_data_i : '0;
        if (idx_rd_i)
            clr_all = clr_all | sel.win;
    end

    uart_irq_pending u_pending (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_set_i),
        .clr_i  (clr_all),
        .pend_o (pend)
    );

    uart_irq_prio_enc u_enc (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend),
        .mask_i (mask_i),
        .sel_o  (sel)
    );

    assign irq_idx_o = sel.code;
    assign irq_o     = |(pend & mask_i);

    p_irq_match_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o == (irq_idx_o != '0));

    p_rdclr_r6: assert property (@(posedge clk) disable iff (rst)
        (idx_rd_i && sel.any && ((sel.win & evt_set_i) == '0))
        |=> ((pend & $past(sel.win)) == '0));

    p_idle_read_r10: assert property (@(posedge clk) disable iff (rst)
        (idx_rd_i && !sel.any && !clr_wr_i && evt_set_i == '0) |=> $stable(pend));

endmodule

// File: tb/tb_uart_irq_index_ctrl.sv
module tb_uart_irq_index_ctrl;

    localparam int N = 19;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] evt_set_i;
    logic [N-1:0] mask_i;
    logic         clr_wr_i;
    logic [N-1:0] clr_data_i;
    logic         idx_rd_i;
    logic [4:0]   irq_idx_o;
    logic         irq_o;

    always #2.5 clk = ~clk;

    uart_irq_index_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .evt_set_i  (evt_set_i),
        .mask_i     (mask_i),
        .clr_wr_i   (clr_wr_i),
        .clr_data_i (clr_data_i),
        .idx_rd_i   (idx_rd_i),
        .irq_idx_o  (irq_idx_o),
        .irq_o      (irq_o)
    );

    int n_run  = 0;
    int n_fail = 0;
    logic [N-1:0] pend_m = '0;
    logic [4:0]   q_idx[$];
    logic         q_irq[$];
    string        q_tag[$];
    bit           done = 0;

    // R3 code map, from the requirement
    function automatic logic [4:0] exp_code(input int b);
        return (b == 18) ? 5'h15 : 5'(b + 1);
    endfunction

    function automatic int first_bit(input logic [N-1:0] v);
        for (int i = 0; i < N; i++)
            if (v[i]) return i;
        return -1;
    endfunction

    task automatic step(input logic [N-1:0] set, input logic [N-1:0] msk,
                        input logic cw, input logic [N-1:0] cd,
                        input logic rd, input string tag);
        int w;
        logic [N-1:0] act;
        @(negedge clk);
        evt_set_i  = set;
        mask_i     = msk;
        clr_wr_i   = cw;
        clr_data_i = cd;
        idx_rd_i   = rd;
        w = first_bit(pend_m & msk);
        if (cw) pend_m = pend_m & ~cd;
        if (rd && w >= 0) pend_m[w] = 1'b0;
        pend_m = pend_m | set;
        act = pend_m & msk;
        w = first_bit(act);
        q_idx.push_back(w < 0 ? 5'h00 : exp_code(w));
        q_irq.push_back(act != '0);
        q_tag.push_back(tag);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_idx.size() > 0) begin
                logic [4:0] ei;
                logic       eq;
                string      t;
                ei = q_idx.pop_front();
                eq = q_irq.pop_front();
                t  = q_tag.pop_front();
                n_run++;
                if (irq_idx_o !== ei || irq_o !== eq) begin
                    n_fail++;
                    $display("FAIL %s: idx=%0h irq=%0b expected idx=%0h irq=%0b",
                             t, irq_idx_o, irq_o, ei, eq);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    localparam logic [N-1:0] ALL = '1;
    localparam logic [N-1:0] NONE = '0;

    initial begin
        rst = 1'b1;
        evt_set_i = '0; mask_i = ALL; clr_wr_i = 0; clr_data_i = '0; idx_rd_i = 0;
        // set pulses during reset must not survive (R1)
        @(negedge clk); evt_set_i = ALL;
        @(negedge clk); evt_set_i = '0;
        @(posedge clk); #1;
        n_run++;
        if (irq_idx_o !== 5'h00 || irq_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: idx=%0h irq=%0b expected idx=0 irq=0", irq_idx_o, irq_o);
        end
        @(negedge clk); rst = 1'b0;
        step(NONE, ALL, 0, NONE, 0, "R1 after release");

        // R2 basic latching and priority
        step(N'(1) << 5, ALL, 0, NONE, 0, "R2 single set bit5");
        step(NONE, ALL, 0, NONE, 0, "R2 flag held");
        step((N'(1) << 3) | (N'(1) << 10), ALL, 0, NONE, 0, "R2 lower bit wins");
        // R6 read walks the flags
        step(NONE, ALL, 0, NONE, 1, "R6 read clears bit3 only");
        step(NONE, ALL, 0, NONE, 1, "R6 read clears bit5 only");
        step(NONE, ALL, 0, NONE, 1, "R6 read clears bit10, R4 zero");
        // R10 read at index 0
        step(NONE, ALL, 0, NONE, 1, "R10 idle read");

        // R3 code map sweep
        for (int b = 0; b < N; b++) begin
            step(N'(1) << b, ALL, 1, ALL, 0, $sformatf("R3 code for bit %0d", b));
        end
        step(NONE, ALL, 1, ALL, 0, "R7 clear all");

        // R3/R6 all pending, walk down with reads to 0
        step(ALL, ALL, 0, NONE, 0, "R2 all pending");
        for (int k = 0; k < N; k++) begin
            step(NONE, ALL, 0, NONE, 1, $sformatf("R6 R3 walk read %0d", k));
        end

        // R9/R4/R5 masked latching
        step((N'(1) << 2) | (N'(1) << 18), NONE, 0, NONE, 0, "R9 masked set, R4 R5 idle");
        step(NONE, NONE, 0, NONE, 1, "R10 read while masked");
        step(NONE, N'(1) << 18, 0, NONE, 0, "R9 enable bit18 exposes 0x15");
        step(NONE, ALL, 0, NONE, 0, "R9 enable all exposes bit2");
        step(NONE, ~(N'(1) << 2), 0, NONE, 0, "R5 mask bit2 again");

        // R7 partial W1C, zeros leave flags
        step((N'(1) << 7) | (N'(1) << 9), ALL, 0, NONE, 0, "R2 set 7 and 9");
        step(NONE, ALL, 1, (N'(1) << 2) | (N'(1) << 9), 0, "R7 clear 2 and 9");
        step(NONE, ALL, 1, N'(1) << 7, 0, "R7 clear 7 leaves 18");

        // R8 set wins over W1C
        step(N'(1) << 4, ALL, 1, N'(1) << 4, 0, "R8 set beats w1c");
        // R8 set wins over read clear of the same winner
        step(N'(1) << 4, ALL, 0, NONE, 1, "R8 set beats read clear");
        step(N'(1) << 1, ALL, 0, NONE, 1, "R6 read of bit4 keeps new bit1");
        step(NONE, ALL, 1, ALL, 0, "R7 clear all final");
        step(NONE, ALL, 0, NONE, 0, "R4 final idle");

        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule